// File: doc/BRIEF.md
# Upgradable Reader-Seeker-Writer Lock Unit

This block keeps one 32-bit shared lock word and lets several requesters change it through a single shared fetch-and-add port. Every lock state is a counter field inside that word, so taking, dropping or converting any lock is one atomic add of a fixed constant. Besides the usual shared-read and exclusive-write modes there is a seek mode. A seek holder runs alongside readers but keeps out other seekers and writers, and it can later turn into a writer without any check for competing writers. There is also an atomic-update mode. It keeps out readers, seekers and writers, but any number of atomic-update holders can share it.

Each requester owns a small state machine. A client starts an operation with a one-cycle start pulse and an operation code. The state machine checks the word for compatibility, posts its add, and inspects the value the add returned. If that value shows a conflict, it takes its add back with a subtract, waits a backoff delay that doubles after each failure, and tries again. Transitions into write or atomic-update mode finish in two phases: the add is posted first, and the requester then waits until the other readers have left. The operation ends with a one-cycle done pulse.

Top module: `plock_unit`

## Requirements
- R1: After reset the lock word reads zero and no requester is busy.
- R2: The word holds the reader count in bits [13:0], the seek count in [15:14], the write count in [29:16] and two application bits in [31:30]. Operation codes: 0 take read (+0x1), 1 drop read, 2 take seek (+0x4001), 3 drop seek, 4 take write (+0x14001), 5 drop write, 6 take atomic (+0x10000), 7 drop atomic. Each drop subtracts its take's constant, and codes 12 to 15 complete without changing the word.
- R3: Conversions: 8 seek to write (+0x10000), 9 write to seek (-0x10000), 10 seek to read (-0x4000), 11 write to read (-0x14000).
- R4: A read take adds nothing and stays busy while the write field is nonzero. It completes once that field is clear.
- R5: A seek take completes while readers are present. It stays busy, adding nothing, while another seek or write is held.
- R6: A write take posts +0x14001 as soon as no seek or write is held. It then stays busy until the reader field equals 1, and it completes in that cycle.
- R7: A seek-to-write upgrade posts +0x10000 without any check and completes once the reader field equals 1.
- R8: An atomic take completes when other atomic holders are present. It stays busy while a seek is held. Once posted, it completes only when the reader field is 0.
- R9: The port serves at most one requester per cycle. N requesters that ask in the same cycle are all served within N consecutive cycles.
- R10: After a failed attempt, a requester waits 1, 2, 4 … up to 1024 cycles, and the wait returns to 1 after a grant. A blocked requester completes within a few cycles of the word becoming compatible.
- R11: A requester that loses a race undoes its add, so the word settles as if only the winner had acted.
- R12: The application bits are never changed by any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | NREQ | One-cycle start pulse per requester |
| cmd_op | input | 4*NREQ | Operation code per requester, 4 bits each |
| cmd_busy | output | NREQ | Requester has an operation in progress |
| cmd_done | output | NREQ | One-cycle pulse: operation granted and finished |
| lock_word | output | 32 | Current lock word |

## Verification
The assertions assume that clients use the locks legally. A client pulses start only while its requester is idle, drops or converts only a lock it holds, and holds at most one lock at a time. Under that assumption no counter field can exceed the number of requesters, and the application bits can never be reached by a carry. The stimulus follows these rules: every operation is issued only after the same requester's previous one has finished, and every drop matches the lock the bench model records as held. Contention comes only from the other requesters, through deliberate same-cycle races and blocked takes.

// File: rtl/plock_pkg.sv
// Shared types and helpers for the lock unit.
// Assumes a 32-bit word with fixed field positions that every requester decodes.
package plock_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] UNIT_RD = 32'h0000_0001;
    localparam logic [WORD_W-1:0] UNIT_SK = 32'h0000_4000;
    localparam logic [WORD_W-1:0] UNIT_WR = 32'h0001_0000;

    typedef enum logic [3:0] {
        OP_TAKE_R  = 4'd0,
        OP_DROP_R  = 4'd1,
        OP_TAKE_S  = 4'd2,
        OP_DROP_S  = 4'd3,
        OP_TAKE_W  = 4'd4,
        OP_DROP_W  = 4'd5,
        OP_TAKE_A  = 4'd6,
        OP_DROP_A  = 4'd7,
        OP_UP_SW   = 4'd8,
        OP_DN_WS   = 4'd9,
        OP_DN_SR   = 4'd10,
        OP_DN_WR   = 4'd11
    } op_t;

    function automatic logic [13:0] rd_cnt(input logic [WORD_W-1:0] w);
        return w[13:0];
    endfunction

    function automatic logic [1:0] sk_cnt(input logic [WORD_W-1:0] w);
        return w[15:14];
    endfunction

    function automatic logic [13:0] wr_cnt(input logic [WORD_W-1:0] w);
        return w[29:16];
    endfunction

    // Constant added to the word by one operation.
    function automatic logic [WORD_W-1:0] op_delta(input op_t op);
        case (op)
            OP_TAKE_R: return UNIT_RD;
            OP_DROP_R: return 32'(0) - UNIT_RD;
            OP_TAKE_S: return UNIT_SK + UNIT_RD;
            OP_DROP_S: return 32'(0) - (UNIT_SK + UNIT_RD);
            OP_TAKE_W: return UNIT_WR + UNIT_SK + UNIT_RD;
            OP_DROP_W: return 32'(0) - (UNIT_WR + UNIT_SK + UNIT_RD);
            OP_TAKE_A: return UNIT_WR;
            OP_DROP_A: return 32'(0) - UNIT_WR;
            OP_UP_SW:  return UNIT_WR;
            OP_DN_WS:  return 32'(0) - UNIT_WR;
            OP_DN_SR:  return 32'(0) - UNIT_SK;
            OP_DN_WR:  return 32'(0) - (UNIT_WR + UNIT_SK);
            default:   return '0;
        endcase
    endfunction

    // Takes that must inspect the returned value and may roll back.
    function automatic logic op_checked(input op_t op);
        return (op == OP_TAKE_R) || (op == OP_TAKE_S) ||
               (op == OP_TAKE_W) || (op == OP_TAKE_A);
    endfunction

    // Transitions that wait for other readers to leave after posting.
    function automatic logic op_waits(input op_t op);
        return (op == OP_TAKE_W) || (op == OP_TAKE_A) || (op == OP_UP_SW);
    endfunction

    // True when word w (without this requester's add) forbids the take.
    function automatic logic op_conflict(input op_t op, input logic [WORD_W-1:0] w);
        case (op)
            OP_TAKE_R: return wr_cnt(w) != '0;
            OP_TAKE_S,
            OP_TAKE_W: return (sk_cnt(w) != '0) || (wr_cnt(w) != '0);
            OP_TAKE_A: return sk_cnt(w) != '0;
            default:   return 1'b0;
        endcase
    endfunction

    // True once only this requester's own reader unit (or none) remains.
    function automatic logic readers_clear(input op_t op, input logic [WORD_W-1:0] w);
        if (op == OP_TAKE_A)
            return rd_cnt(w) == '0;
        return rd_cnt(w) == 14'd1;
    endfunction

endpackage

// File: rtl/plock_rr_arb.sv
// Round-robin arbiter for the fetch-and-add port.
// Grants at most one requester per cycle; search starts after the last winner.
module plock_rr_arb #(
    parameter int NREQ = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt
);
    localparam int PW = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [PW-1:0] ptr;
    int            win;

    // Pick the first requester at or after the rotating pointer.
    always_comb begin
        int idx;
        gnt = '0;
        win = 0;
        for (int k = 0; k < NREQ; k++) begin
            idx = int'(ptr) + k;
            if (idx >= NREQ)
                idx = idx - NREQ;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = idx;
            end
        end
    end

    // Advance the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (gnt != '0)
            ptr <= (win + 1 >= NREQ) ? '0 : PW'(win + 1);
    end

    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_grant_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

endmodule

// File: rtl/plock_word.sv
// Lock word register with a single-cycle fetch-and-add.
// Assumes gnt is one-hot or zero; the old value is the register itself.
module plock_word #(
    parameter int NREQ = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        gnt,
    input  logic [NREQ-1:0][31:0]  delta,
    output logic [31:0]            word
);
    import plock_pkg::*;

    logic [31:0] sel_delta;

    // Select the granted requester's constant.
    always_comb begin
        sel_delta = '0;
        for (int i = 0; i < NREQ; i++)
            if (gnt[i])
                sel_delta = sel_delta | delta[i];
    end

    // Apply the add at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (gnt != '0)
            word <= word + sel_delta;
    end

    assert_reader_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_cnt(word)) <= NREQ);
    assert_app_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(word[31:30]));

endmodule

// File: rtl/plock_requester.sv
// Per-requester lock state machine: check, post, verify, roll back, back off,
// and wait for readers. Assumes start only while idle.
module plock_requester #(
    parameter int BO_MAX = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  plock_pkg::op_t  op,
    input  logic [31:0]     word,
    input  logic            gnt,
    output logic            req,
    output logic [31:0]     delta,
    output logic            busy,
    output logic            done
);
    import plock_pkg::*;

    localparam int CW = $clog2(BO_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_PEEK, ST_ADD, ST_CHECK, ST_UNDO, ST_BACK, ST_WAITR
    } st_t;

    st_t           state;
    op_t           op_q;
    logic [31:0]   old_q;
    logic [CW-1:0] bo_len;
    logic [CW-1:0] bo_cnt;

    // Port request and the constant to add (negated while undoing).
    always_comb begin
        req   = (state == ST_ADD) || (state == ST_UNDO);
        delta = (state == ST_UNDO) ? 32'(0) - op_delta(op_q) : op_delta(op_q);
        busy  = (state != ST_IDLE);
    end

    // Completion pulse in whichever state finishes the operation.
    always_comb begin
        done = 1'b0;
        case (state)
            ST_ADD:   done = gnt && !op_checked(op_q) && !op_waits(op_q);
            ST_CHECK: done = !op_conflict(op_q, old_q) && !op_waits(op_q);
            ST_WAITR: done = readers_clear(op_q, word);
            default:  done = 1'b0;
        endcase
    end

    // Operation sequencing and backoff bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_TAKE_R;
            old_q  <= '0;
            bo_len <= CW'(1);
            bo_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    op_q  <= op;
                    state <= op_checked(op) ? ST_PEEK : ST_ADD;
                end
                ST_PEEK: if (!op_conflict(op_q, word))
                    state <= ST_ADD;
                ST_ADD: if (gnt) begin
                    old_q <= word;
                    if (op_checked(op_q))
                        state <= ST_CHECK;
                    else if (op_waits(op_q))
                        state <= ST_WAITR;
                    else begin
                        state  <= ST_IDLE;
                        bo_len <= CW'(1);
                    end
                end
                ST_CHECK: begin
                    if (op_conflict(op_q, old_q))
                        state <= ST_UNDO;
                    else if (op_waits(op_q))
                        state <= ST_WAITR;
                    else begin
                        state  <= ST_IDLE;
                        bo_len <= CW'(1);
                    end
                end
                ST_UNDO: if (gnt) begin
                    bo_cnt <= bo_len;
                    bo_len <= (bo_len >= CW'(BO_MAX / 2)) ? CW'(BO_MAX) : (bo_len << 1);
                    state  <= ST_BACK;
                end
                ST_BACK: begin
                    if (bo_cnt <= CW'(1))
                        state <= ST_PEEK;
                    else
                        bo_cnt <= bo_cnt - CW'(1);
                end
                ST_WAITR: if (readers_clear(op_q, word)) begin
                    state  <= ST_IDLE;
                    bo_len <= CW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_backoff_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BACK) |-> (bo_cnt != '0 && bo_cnt <= CW'(BO_MAX)));
    assert_write_posted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && op_q == OP_TAKE_W) |-> (wr_cnt(word) != '0));
    assert_wait_holds_w_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITR) |-> (wr_cnt(word) != '0));
    assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/plock_unit.sv
// Top of the lock unit: NREQ requesters share one lock word through a
// round-robin fetch-and-add port. Assumes clients obey lock discipline.
module plock_unit #(
    parameter int NREQ   = 3,
    parameter int BO_MAX = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   cmd_start,
    input  logic [4*NREQ-1:0] cmd_op,
    output logic [NREQ-1:0]   cmd_busy,
    output logic [NREQ-1:0]   cmd_done,
    output logic [31:0]       lock_word
);
    import plock_pkg::*;

    logic [NREQ-1:0]       port_req;
    logic [NREQ-1:0]       port_gnt;
    logic [NREQ-1:0][31:0] port_delta;

    plock_rr_arb #(.NREQ(NREQ)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (port_req),
        .gnt   (port_gnt)
    );

    plock_word #(.NREQ(NREQ)) word_i (
        .clk   (clk),
        .rst_n (rst_n),
        .gnt   (port_gnt),
        .delta (port_delta),
        .word  (lock_word)
    );

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        plock_requester #(.BO_MAX(BO_MAX)) req_i (
            .clk   (clk),
            .rst_n (rst_n),
            .start (cmd_start[g]),
            .op    (op_t'(cmd_op[4*g +: 4])),
            .word  (lock_word),
            .gnt   (port_gnt[g]),
            .req   (port_req[g]),
            .delta (port_delta[g]),
            .busy  (cmd_busy[g]),
            .done  (cmd_done[g])
        );
    end

endmodule

// File: tb/plock_unit_tb_top.sv
module plock_unit_tb_top;
    localparam int N = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    start = '0;
    logic [4*N-1:0]  op = '0;
    logic [N-1:0]    busy;
    logic [N-1:0]    done;
    logic [31:0]     word;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int held [N];
    int last_op [N];
    int done_cnt [N];
    int done_cyc [N];

    always #4 clk = ~clk;

    plock_unit #(.NREQ(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(start), .cmd_op(op),
        .cmd_busy(busy), .cmd_done(done), .lock_word(word)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Held lock: 0 none, 1 read, 2 seek, 3 write, 4 atomic.
    function automatic logic [31:0] contrib(input int h);
        case (h)
            1: return 32'h1;
            2: return 32'h4001;
            3: return 32'h14001;
            4: return 32'h10000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_word();
        logic [31:0] s = '0;
        for (int i = 0; i < N; i++) s += contrib(held[i]);
        return s;
    endfunction

    function automatic int next_held(input int o, input int h);
        case (o)
            0: return 1;  2: return 2;  4: return 3;  6: return 4;
            1, 3, 5, 7: return 0;
            8: return 3;  9: return 2;  10: return 1; 11: return 1;
            default: return h;
        endcase
    endfunction

    // Reference model, compared on every clock while all requesters rest.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (done[i]) begin
                    done_cnt[i]++;
                    done_cyc[i] = cyc;
                    held[i] = next_held(last_op[i], held[i]);
                    if (last_op[i] == 4 || last_op[i] == 8)
                        chk(word[13:0] == 14'd1, "R6 R7 sole reader at grant", word, 32'h1);
                    if (last_op[i] == 6)
                        chk(word[13:0] == 14'd0, "R8 no reader at grant", word, 32'h0);
                end
            end
            chk(word[31:30] == 2'b00, "R12 app bits", {30'd0, word[31:30]}, 32'h0);
            if (busy == '0 && done == '0)
                chk(word == model_word(), "R2 R3 model word", word, model_word());
        end
    end

    task automatic issue(input int i, input int o);
        @(negedge clk);
        last_op[i] = o;
        op[4*i +: 4] = 4'(o);
        start[i] = 1'b1;
        @(negedge clk);
        start[i] = 1'b0;
    endtask

    task automatic wait_done(input int i, input string rq);
        int n = 0;
        while (busy[i] && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy[i], rq, {31'd0, busy[i]}, 32'h0);
    endtask

    task automatic run(input int i, input int o, input string rq);
        issue(i, o);
        wait_done(i, rq);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int t0, mn, mx;
        int d0, d1, win, los;
        for (int i = 0; i < N; i++) begin
            held[i] = 0; last_op[i] = 0; done_cnt[i] = 0; done_cyc[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word == 32'h0, "R1 reset word", word, 32'h0);
        chk(busy == '0, "R1 reset busy", {29'd0, busy}, 32'h0);

        // R2: read take and drop
        run(0, 0, "R2 take read");
        chk(word == 32'h1, "R2 read unit", word, 32'h1);
        run(0, 1, "R2 drop read");
        chk(word == 32'h0, "R2 read dropped", word, 32'h0);
        run(1, 13, "R2 undefined code");
        chk(word == 32'h0, "R2 undefined code no change", word, 32'h0);

        // R5, R7, R3: seek with readers, upgrade, conversions
        run(0, 2, "R5 take seek");
        chk(word == 32'h4001, "R2 seek units", word, 32'h4001);
        run(1, 0, "R5 reader beside seek");
        chk(word == 32'h4002, "R5 coexist", word, 32'h4002);
        issue(2, 2);
        repeat (30) @(negedge clk);
        chk(busy[2], "R5 second seek blocked", {31'd0, busy[2]}, 32'h1);
        chk(word == 32'h4002, "R5 blocked seek adds nothing", word, 32'h4002);
        issue(0, 8);
        repeat (20) @(negedge clk);
        chk(busy[0], "R7 upgrade waits for reader", {31'd0, busy[0]}, 32'h1);
        chk(word == 32'h14002, "R7 upgrade posted", word, 32'h14002);
        run(1, 1, "R7 reader leaves");
        wait_done(0, "R7 upgrade completes");
        chk(word == 32'h14001, "R7 word after upgrade", word, 32'h14001);
        run(0, 9, "R3 write to seek");
        chk(word == 32'h4001, "R3 write to seek value", word, 32'h4001);
        chk(busy[2], "R5 still blocked by seek", {31'd0, busy[2]}, 32'h1);
        run(0, 10, "R3 seek to read");
        wait_done(2, "R5 seek granted after release");
        chk(word == 32'h4002, "R5 second seek holds", word, 32'h4002);
        run(0, 1, "R2 drop read");
        run(2, 3, "R2 drop seek");

        // R4: reader waits for writer
        run(0, 4, "R4 take write");
        chk(word == 32'h14001, "R2 write units", word, 32'h14001);
        issue(1, 0);
        repeat (30) @(negedge clk);
        chk(busy[1], "R4 reader blocked", {31'd0, busy[1]}, 32'h1);
        chk(word == 32'h14001, "R4 reader adds nothing", word, 32'h14001);
        run(0, 11, "R3 write to read");
        wait_done(1, "R4 reader granted");
        chk(word == 32'h2, "R3 R4 two readers", word, 32'h2);
        run(0, 1, "R2 drop");
        run(1, 1, "R2 drop");

        // R6: writer waits for all other readers
        run(1, 0, "R6 reader a");
        run(2, 0, "R6 reader b");
        issue(0, 4);
        repeat (20) @(negedge clk);
        chk(busy[0], "R6 writer waits", {31'd0, busy[0]}, 32'h1);
        chk(word == 32'h14003, "R6 write posted", word, 32'h14003);
        run(1, 1, "R6 reader a leaves");
        repeat (10) @(negedge clk);
        chk(busy[0], "R6 writer still waits", {31'd0, busy[0]}, 32'h1);
        run(2, 1, "R6 reader b leaves");
        wait_done(0, "R6 writer granted");
        run(0, 5, "R2 drop write");

        // R8: atomic mode
        run(0, 6, "R8 atomic a");
        run(1, 6, "R8 atomic b");
        chk(word == 32'h20000, "R8 two atomic holders", word, 32'h20000);
        issue(2, 2);
        repeat (20) @(negedge clk);
        chk(busy[2], "R8 seek blocked by atomic", {31'd0, busy[2]}, 32'h1);
        run(0, 7, "R8 drop atomic");
        run(1, 7, "R8 drop atomic");
        wait_done(2, "R8 seek after atomics");
        issue(0, 6);
        repeat (20) @(negedge clk);
        chk(busy[0], "R8 atomic blocked by seek", {31'd0, busy[0]}, 32'h1);
        chk(word == 32'h4001, "R8 blocked atomic adds nothing", word, 32'h4001);
        run(2, 3, "R8 seek leaves");
        wait_done(0, "R8 atomic granted");
        run(0, 7, "R8 drop");
        run(1, 0, "R8 reader");
        issue(0, 6);
        repeat (20) @(negedge clk);
        chk(busy[0], "R8 atomic waits for reader", {31'd0, busy[0]}, 32'h1);
        chk(word == 32'h10001, "R8 atomic posted", word, 32'h10001);
        run(1, 1, "R8 reader leaves");
        wait_done(0, "R8 atomic granted after reader");
        run(0, 7, "R8 drop");

        // R9: three simultaneous requests
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            last_op[i] = 0; op[4*i +: 4] = 4'd0;
        end
        start = '1;
        @(negedge clk);
        start = '0;
        for (int i = 0; i < N; i++) wait_done(i, "R9 all served");
        mn = done_cyc[0]; mx = done_cyc[0];
        for (int i = 1; i < N; i++) begin
            if (done_cyc[i] < mn) mn = done_cyc[i];
            if (done_cyc[i] > mx) mx = done_cyc[i];
        end
        chk(mx - mn == N - 1, "R9 spread", 32'(mx - mn), 32'(N - 1));
        chk(done_cyc[0] != done_cyc[1] && done_cyc[1] != done_cyc[2] && done_cyc[0] != done_cyc[2],
            "R9 one per cycle", 32'(done_cyc[0]), 32'(done_cyc[1]));
        chk(word == 32'h3, "R9 three readers", word, 32'h3);
        for (int i = 0; i < N; i++) run(i, 1, "R9 drop");

        // R11: seek race, loser rolls back
        d0 = done_cnt[0]; d1 = done_cnt[1];
        @(negedge clk);
        last_op[0] = 2; last_op[1] = 2;
        op[3:0] = 4'd2; op[7:4] = 4'd2;
        start[1:0] = 2'b11;
        @(negedge clk);
        start[1:0] = 2'b00;
        repeat (20) @(negedge clk);
        chk(word == 32'h4001, "R11 word after race", word, 32'h4001);
        chk((done_cnt[0] - d0) + (done_cnt[1] - d1) == 1, "R11 one winner",
            32'((done_cnt[0] - d0) + (done_cnt[1] - d1)), 32'h1);
        win = (done_cnt[0] != d0) ? 0 : 1;
        los = 1 - win;
        chk(busy[los], "R11 loser retries", {31'd0, busy[los]}, 32'h1);
        run(win, 3, "R11 winner drops");
        wait_done(los, "R11 loser granted");
        chk(word == 32'h4001, "R11 loser holds", word, 32'h4001);
        run(los, 3, "R11 drop");

        // R10: long block then prompt grant
        run(0, 4, "R10 writer");
        issue(1, 0);
        repeat (3000) @(negedge clk);
        chk(busy[1], "R10 reader still waiting", {31'd0, busy[1]}, 32'h1);
        t0 = cyc;
        run(0, 5, "R10 writer drops");
        wait_done(1, "R10 reader granted");
        chk(done_cyc[1] - t0 <= 8, "R10 prompt grant", 32'(done_cyc[1] - t0), 32'd8);
        run(1, 1, "R10 drop");

        repeat (5) @(negedge clk);
        chk(word == 32'h0, "R2 final unlocked", word, 32'h0);
        finish_run();
    end
endmodule